// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic down-counting timer that sits on a simple word-addressed register bus. It counts down from a programmable reload value. Once the count is at zero, the next count event loads the reload value back in, so the timer produces a steady period. Each count event comes from one of two places: every core clock cycle, or each rising edge of a slow reference tick that arrives asynchronously to the core clock.

Software can enable or stop the count, pick the count source and read the live count. Writing any value to the count clears it. Software can also poll a sticky wrap flag, or enable a one-cycle interrupt request pulse on each wrap. A read-only calibration word is built from parameters. It reports three things: whether a reference tick exists, whether the ten-millisecond figure is inexact, and how many reference ticks make up ten milliseconds.

Top module: `tick_timer`

## Requirements
- R1: After reset, and with a reference present, the control word, the reload value and the count all read 0, and irq_o is low.
- R2: Registers are selected by addr_i[3:2]: 0 control, 1 reload, 2 count, 3 calibration. The reload value keeps bits 23:0 only, and its upper bits read as 0.
- R3: While control bit 0 (enable) is 0, the count holds its value.
- R4: With control bit 2 at 1, the count changes once per core clock. With bit 2 at 0, it changes only on reference edges.
- R5: On the reference source, each rising edge of ref_clk_i produces exactly one count event, however long the tick stays high. Falling edges produce none.
- R6: A write of any data to the count register sets the count to 0 and clears the wrap flag. The write takes priority over a count event in the same cycle.
- R7: A count event at count 0 loads the reload value. With a reload value of 0, the count stays at 0 and never wraps.
- R8: Control bit 16 (wrap flag) is set when a count event takes the count from 1 to 0. A control read clears it, but a wrap in the same cycle as the read wins.
- R9: With control bit 1 set, irq_o pulses high for exactly one cycle on each 1-to-0 wrap. With bit 1 clear, irq_o stays low.
- R10: The calibration word reads bit 31 = 1 when no reference exists, bit 30 = the skew parameter, bits 23:0 = the ten-millisecond tick count, and 0 in all other bits.
- R11: Without a reference, control bit 2 reads 1 and the count runs on the core clock, whatever is written to that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | 1 | Asynchronous reference tick |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 4 | Byte address of the word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 1 | One-cycle wrap interrupt request |

## Verification
The bench aims at the cycle where a wrap and a control read meet. A design that lets the clear win there silently loses a wrap event. It also writes the count while the timer is running: a design that gives the count event priority would read back the reload value or a decremented value instead of 0. A reference tick is held high for many cycles to catch a level-sensitive enable, which would drain the count. A zero reload value and the instance with no reference expose a design that wraps from 0 or that honours a clock-source bit that has no reference behind it.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int DATA_W = 32;

  localparam logic [1:0] SEL_CTRL   = 2'd0;
  localparam logic [1:0] SEL_RELOAD = 2'd1;
  localparam logic [1:0] SEL_COUNT  = 2'd2;
  localparam logic [1:0] SEL_CALIB  = 2'd3;

  localparam int BIT_EN    = 0;
  localparam int BIT_IRQEN = 1;
  localparam int BIT_CORE  = 2;
  localparam int BIT_WRAP  = 16;
  localparam int BIT_NOREF = 31;
  localparam int BIT_SKEW  = 30;

  typedef struct packed {
    logic core;
    logic irq_en;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/tick_ref_sync.sv
module tick_ref_sync #(
  parameter bit HAS_REF = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic edge_o
);
  if (HAS_REF) begin : g_sync
    logic [2:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[1:0], ref_i};
    end
    // sh_q[1] is the synchronized level, sh_q[2] its previous value
    assign edge_o = sh_q[1] & ~sh_q[2];
  end else begin : g_none
    logic unused_ref;
    assign unused_ref = ref_i;
    assign edge_o     = 1'b0;
  end
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             ctrl_rd_i,
  input  logic             irq_en_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap_q, irq_q, hit;

  assign hit = tick_i & ~clr_i & (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= hit & irq_en_i;
      if (clr_i)       cnt_q <= '0;
      else if (tick_i) cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - ONE;
      // a wrap in the cycle of a clearing read is kept
      if (hit)                     wrap_q <= 1'b1;
      else if (clr_i || ctrl_rd_i) wrap_q <= 1'b0;
    end
  end

  assign count_o = cnt_q;
  assign wrap_o  = wrap_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_pkg::*;
#(
  parameter int             CNT_W     = 24,
  parameter bit             HAS_REF   = 1'b1,
  parameter bit             CAL_SKEW  = 1'b0,
  parameter logic [CNT_W-1:0] CAL_TENMS = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              wrap_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              clr_o,
  output logic              ctrl_rd_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int PAD = DATA_W - CNT_W;

  logic [1:0]       sel;
  logic             wr;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic             unused_bits;

  assign sel         = addr_i[3:2];
  assign wr          = req_i & we_i;
  assign unused_bits = ^{addr_i[1:0], wdata_i[DATA_W-1:CNT_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '{core: ~HAS_REF, irq_en: 1'b0, en: 1'b0};
      reload_q <= '0;
    end else if (wr) begin
      if (sel == SEL_CTRL) begin
        ctrl_q.en     <= wdata_i[BIT_EN];
        ctrl_q.irq_en <= wdata_i[BIT_IRQEN];
        ctrl_q.core   <= HAS_REF ? wdata_i[BIT_CORE] : 1'b1;
      end
      if (sel == SEL_RELOAD) reload_q <= wdata_i[CNT_W-1:0];
    end
  end

  assign clr_o     = wr & (sel == SEL_COUNT);
  assign ctrl_rd_o = req_i & ~we_i & (sel == SEL_CTRL);
  assign ctrl_o    = ctrl_q;
  assign reload_o  = reload_q;

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_CTRL: begin
        rdata_o[BIT_EN]    = ctrl_q.en;
        rdata_o[BIT_IRQEN] = ctrl_q.irq_en;
        rdata_o[BIT_CORE]  = ctrl_q.core;
        rdata_o[BIT_WRAP]  = wrap_i;
      end
      SEL_RELOAD: rdata_o = {{PAD{1'b0}}, reload_q};
      SEL_COUNT:  rdata_o = {{PAD{1'b0}}, count_i};
      SEL_CALIB: begin
        rdata_o[CNT_W-1:0] = CAL_TENMS;
        rdata_o[BIT_NOREF] = ~HAS_REF;
        rdata_o[BIT_SKEW]  = CAL_SKEW;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int               CNT_W     = 24,
  parameter bit               HAS_REF   = 1'b1,
  parameter bit               CAL_SKEW  = 1'b1,
  parameter logic [CNT_W-1:0] CAL_TENMS = CNT_W'(1000)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_clk_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload, cnt_q;
  logic             clr, ctrl_rd, wrap_q, ref_edge, cnt_tick;

  tick_ref_sync #(.HAS_REF(HAS_REF)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ref_i (ref_clk_i),
    .edge_o(ref_edge)
  );

  tick_regs #(
    .CNT_W(CNT_W), .HAS_REF(HAS_REF), .CAL_SKEW(CAL_SKEW), .CAL_TENMS(CAL_TENMS)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .count_i  (cnt_q),
    .wrap_i   (wrap_q),
    .ctrl_o   (ctrl),
    .reload_o (reload),
    .clr_o    (clr),
    .ctrl_rd_o(ctrl_rd),
    .rdata_o  (rdata_o)
  );

  assign cnt_tick = ctrl.en & (ctrl.core | ref_edge);

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (cnt_tick),
    .clr_i    (clr),
    .ctrl_rd_i(ctrl_rd),
    .irq_en_i (ctrl.irq_en),
    .reload_i (reload),
    .count_o  (cnt_q),
    .wrap_o   (wrap_q),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick,
  input logic             clr,
  input logic             en,
  input logic             ref_edge,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload,
  input logic             wrap,
  input logic             irq
);
  // R3
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !clr) |=> $stable(count));
  // R6
  clear_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (count == '0) && !wrap);
  // R7
  reload_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !clr && count == '0) |=> count == $past(reload));
  // R8
  wrap_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !clr && count == CNT_W'(1)) |=> wrap);
  // R9
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq |=> !irq);
  // R9
  irq_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq |-> (count == '0) && wrap);
  // R5
  ref_edge_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_edge |=> !ref_edge);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick    (cnt_tick),
  .clr     (clr),
  .en      (ctrl.en),
  .ref_edge(ref_edge),
  .count   (cnt_q),
  .reload  (reload),
  .wrap    (wrap_q),
  .irq     (irq_o)
);

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
  localparam logic [3:0] A_CTRL = 4'h0, A_REL = 4'h4, A_CUR = 4'h8, A_CAL = 4'hC;

  logic        clk = 1'b0, rst_n = 1'b0, ref_clk = 1'b0;
  logic        req = 1'b0, we = 1'b0, sel_b = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        irq_a, irq_b;
  int          checks = 0, errors = 0, irq_cnt = 0;
  bit          done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  tick_timer #(.CNT_W(24), .HAS_REF(1'b1), .CAL_SKEW(1'b1), .CAL_TENMS(24'd1000)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .req_i(req & ~sel_b), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_a), .irq_o(irq_a));

  tick_timer #(.CNT_W(24), .HAS_REF(1'b0), .CAL_SKEW(1'b0), .CAL_TENMS(24'd250)) dut_nr (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(1'b0), .req_i(req & sel_b), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_b), .irq_o(irq_b));

  always @(negedge clk) if (irq_a) irq_cnt++;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per read cycle
  initial forever begin
    @(negedge clk);
    #2;
    if (req && !we) begin
      if (exp_q.size() == 0) chk(32'hx, 32'h0, "scoreboard-underrun");
      else chk(sel_b ? rdata_b : rdata_a, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic ref_level(input logic v, input int n);
    @(negedge clk);
    ref_clk = v;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R10 calibration
    rd(A_CTRL, 32'h0, "R1 ctrl");
    rd(A_REL,  32'h0, "R1 reload");
    rd(A_CUR,  32'h0, "R1 count");
    chk({31'b0, irq_a}, 32'h0, "R1 irq");
    rd(A_CAL, 32'h4000_03E8, "R10 calib");

    // R2 reload width
    wr(A_REL, 32'hFFFF_FFFF);
    rd(A_REL, 32'h00FF_FFFF, "R2 reload upper bits");
    wr(A_REL, 32'd3);
    rd(A_REL, 32'd3, "R2 reload");

    // R4 core clock, R7 reload, R8 wrap, R9 irq
    wr(A_CUR, 32'h55);
    wr(A_CTRL, 32'h7);
    rd(A_CUR, 32'd0, "R4 count start");
    rd(A_CUR, 32'd3, "R7 load from zero");
    rd(A_CUR, 32'd2, "R4 dec");
    rd(A_CUR, 32'd1, "R4 dec");
    rd(A_CUR, 32'd0, "R4 reach zero");
    rd(A_CUR, 32'd3, "R7 reload period");
    wr(A_CTRL, 32'h0);
    rd(A_CUR, 32'd1, "R3 hold");
    rd(A_CUR, 32'd1, "R3 hold again");
    rd(A_CTRL, 32'h0001_0000, "R8 wrap set");
    rd(A_CTRL, 32'h0, "R8 wrap cleared by read");
    chk(irq_cnt, 1, "R9 one pulse per wrap");

    // R8 wrap wins over clearing read, R9 irq disabled
    wr(A_CTRL, 32'h5);
    rd(A_CTRL, 32'h5, "R8 read in wrap cycle");
    rd(A_CTRL, 32'h0001_0005, "R8 wrap kept");
    rd(A_CTRL, 32'h5, "R8 cleared");
    wr(A_CTRL, 32'h0);
    chk(irq_cnt, 1, "R9 no irq when disabled");

    // R7 zero reload, R6 clear
    wr(A_REL, 32'd0);
    wr(A_CUR, 32'hABCDEF);
    rd(A_CUR, 32'd0, "R6 any data clears");
    wr(A_CTRL, 32'h5);
    rd(A_CUR, 32'd0, "R7 zero reload stays");
    rd(A_CUR, 32'd0, "R7 zero reload stays");
    rd(A_CTRL, 32'h5, "R7 no wrap at zero reload");

    // R6 clear while running
    wr(A_CTRL, 32'h0);
    wr(A_REL, 32'hFF_FFFF);
    wr(A_CUR, 32'h0);
    wr(A_CTRL, 32'h5);
    rd(A_CUR, 32'd0, "R6 start");
    rd(A_CUR, 32'hFF_FFFF, "R7 max reload");
    rd(A_CUR, 32'hFF_FFFE, "R4 dec");
    wr(A_CUR, 32'h12345);
    rd(A_CUR, 32'd0, "R6 write beats tick");
    rd(A_CUR, 32'hFF_FFFF, "R6 resumes");
    wr(A_CTRL, 32'h0);

    // R5 reference edges, R4 reference source
    wr(A_REL, 32'd10);
    wr(A_CUR, 32'h0);
    wr(A_CTRL, 32'h1);
    rd(A_CUR, 32'd0, "R4 no ref edge no count");
    rd(A_CUR, 32'd0, "R4 no ref edge no count");
    ref_level(1'b1, 8);
    ref_level(1'b0, 8);
    rd(A_CUR, 32'd10, "R5 first edge loads");
    ref_level(1'b1, 2);
    ref_level(1'b0, 6);
    rd(A_CUR, 32'd9, "R5 short tick");
    ref_level(1'b1, 30);
    rd(A_CUR, 32'd8, "R5 long tick counts once");
    ref_level(1'b0, 6);
    rd(A_CUR, 32'd8, "R5 falling edge ignored");
    wr(A_CTRL, 32'h0);

    // R11 no reference instance, R10 calibration
    sel_b = 1'b1;
    rd(A_CAL, 32'h8000_00FA, "R10 calib no ref");
    wr(A_REL, 32'd2);
    wr(A_CTRL, 32'h1);
    rd(A_CUR, 32'd0, "R11 start");
    rd(A_CUR, 32'd2, "R11 core clock load");
    rd(A_CUR, 32'd1, "R11 core clock dec");
    rd(A_CTRL, 32'h0001_0005, "R11 source bit reads 1");
    sel_b = 1'b0;

    repeat (3) @(negedge clk);
    chk(exp_q.size(), 0, "scoreboard drained");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule